// File: doc/BRIEF.md
# DMA Channel Command and Status Controller

This block is the control core of one channel of a multi-mode memory engine. It holds the channel's general configuration word, the selected operation mode, the next-descriptor pointer and an activation register. Software drives it over a simple synchronous register bus. Writes take effect on the clock edge, and reads come back combinationally from the addressed register. Writing command bits to the activation register moves the channel between idle, active and paused. Commands that are not legal in the current state leave the state alone and set sticky error flags.

The datapath itself is not part of this block. That covers descriptor fetch, data movement, and the XOR, CRC32, ECC-scrub and fill engines. A single-cycle `dp_done` pulse stands in for all of them. While the channel is active, that pulse returns it to idle and raises a one-cycle completion interrupt.

Register map (word address on `bus_addr`): 0 = configuration, 1 = mode select, 2 = next-descriptor pointer, 3 = activation (commands on write, status on read).

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset the channel is idle. The configuration register reads 0x0000_1440: bit 12 is the access-protect bit and is set, bits [7:4] are the source burst limit (4) and bits [11:8] are the destination burst limit (4). The mode is plain copy (code 0), the pointer reads 0, the activation register reads 0 and `done_irq` is low.
- R2: Configuration reads return the mode in bits [2:0]. A write to the configuration register updates bits [DW-1:3] and leaves the mode unchanged.
- R3: The mode changes only through a write to address 1. Codes 0 (plain copy), 1 (XOR), 2 (CRC32), 3 (ECC scrub) and 4 (memory fill) are accepted, and codes 5 to 7 are ignored. Address 1 reads the mode zero-extended.
- R4: A pointer write is rejected when it is misaligned for the current mode: bits [5:0] must be clear in XOR mode, and bits [4:0] must be clear in plain-copy and CRC32 modes. ECC scrub and memory fill impose no rule. A rejected write leaves the pointer unchanged and sets the sticky alignment flag, bit 10 of the activation register.
- R5: Activation write data uses these command bits: bit 0 start, bit 1 stop, bit 2 pause, bit 3 restart. A start moves the channel from idle or paused to active.
- R6: A start while active leaves the channel active and sets the sticky start-while-busy flag, bit 9.
- R7: A pause moves active to paused, and a restart moves paused to active.
- R8: A stop moves active to idle. A stop while idle changes nothing and sets no flag.
- R9: The following commands leave the state unchanged and set the sticky illegal-command flag, bit 8: a pause when not active, a restart when not paused, a stop while paused, or more than one command bit in a single write.
- R10: A `dp_done` pulse while the channel is active returns it to idle and holds `done_irq` high for exactly the following cycle. A `dp_done` pulse in any other state is ignored.
- R11: The activation register reports status in bits [5:4] (0 idle, 1 active, 2 paused; 3 never appears). Writing 1 to any of bits [10:8] clears the matching flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data of the addressed register |
| dp_done | input | 1 | Datapath completion pulse |
| chan_mode | output | 3 | Current operation mode |
| chan_state | output | 2 | Current channel state |
| done_irq | output | 1 | One-cycle completion interrupt |

## Verification
The assertions assume that `dp_done` is a single-cycle pulse. They also assume that no command write to the activation register lands in the same cycle as a `dp_done` pulse while the channel is active, because in that cycle the completion takes precedence and the command is dropped. The stimulus raises `dp_done` for one cycle only, and only with the bus quiet. Every bus access is a single-cycle write or a read sampled mid-cycle, so each command is evaluated against a settled state.

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl #(
  parameter int DW         = 32,
  parameter int XOR_ALIGN  = 6,
  parameter int COPY_ALIGN = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          dp_done,
  output logic [2:0]    chan_mode,
  output logic [1:0]    chan_state,
  output logic          done_irq
);
  localparam logic [1:0] A_CFG = 2'd0, A_MODE = 2'd1, A_PTR = 2'd2, A_ACT = 2'd3;
  localparam logic [2:0] M_COPY = 3'd0, M_XOR = 3'd1, M_CRC = 3'd2, M_LAST = 3'd4;
  localparam logic [1:0] S_IDLE = 2'd0, S_ACT = 2'd1, S_PAUSE = 2'd2;
  localparam logic [DW-1:0] XOR_MASK  = DW'((64'd1 << XOR_ALIGN) - 64'd1);
  localparam logic [DW-1:0] COPY_MASK = DW'((64'd1 << COPY_ALIGN) - 64'd1);
  localparam logic [DW-1:0] CFG_RST   = DW'(32'h0000_1440);

  logic [DW-1:3] cfg_q;
  logic [2:0]    mode_q;
  logic [DW-1:0] ptr_q;
  logic [1:0]    st_q, st_d;
  logic [2:0]    flg_q, flg_d;
  logic          irq_q;
  logic          ill, serr, abad;

  wire       wr_cfg  = bus_wr && bus_addr == A_CFG;
  wire       wr_mode = bus_wr && bus_addr == A_MODE;
  wire       wr_ptr  = bus_wr && bus_addr == A_PTR;
  wire       wr_act  = bus_wr && bus_addr == A_ACT;
  wire [3:0] cmd     = bus_wdata[3:0];
  wire       multi   = |(cmd & (cmd - 4'd1));
  wire       finish  = dp_done && st_q == S_ACT;

  assign abad = (mode_q == M_XOR && |(bus_wdata & XOR_MASK)) ||
                ((mode_q == M_COPY || mode_q == M_CRC) && |(bus_wdata & COPY_MASK));

  always_comb begin
    st_d = st_q;
    ill  = 1'b0;
    serr = 1'b0;
    if (finish) st_d = S_IDLE;
    else if (wr_act && cmd != 4'd0) begin
      if (multi) ill = 1'b1;
      else if (cmd[0]) begin
        if (st_q == S_ACT) serr = 1'b1;
        else st_d = S_ACT;
      end else if (cmd[1]) begin
        if (st_q == S_ACT) st_d = S_IDLE;
        else if (st_q == S_PAUSE) ill = 1'b1;
      end else if (cmd[2]) begin
        if (st_q == S_ACT) st_d = S_PAUSE;
        else ill = 1'b1;
      end else begin
        if (st_q == S_PAUSE) st_d = S_ACT;
        else ill = 1'b1;
      end
    end
  end

  assign flg_d = (wr_act ? (flg_q & ~bus_wdata[10:8]) : flg_q) |
                 {wr_ptr && abad, serr, ill};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RST[DW-1:3];
      mode_q <= M_COPY;
      ptr_q  <= '0;
      st_q   <= S_IDLE;
      flg_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= bus_wdata[DW-1:3];
      if (wr_mode && bus_wdata[2:0] <= M_LAST) mode_q <= bus_wdata[2:0];
      if (wr_ptr && !abad) ptr_q <= bus_wdata;
      st_q  <= st_d;
      flg_q <= flg_d;
      irq_q <= finish;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = {cfg_q, mode_q};
      A_MODE:  bus_rdata = DW'(mode_q);
      A_PTR:   bus_rdata = ptr_q;
      default: bus_rdata = DW'({flg_q, 2'b00, st_q, 4'b0000});
    endcase
  end

  assign chan_mode  = mode_q;
  assign chan_state = st_q;
  assign done_irq   = irq_q;

  // R11
  state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_state != 2'd3);
  // R2
  cfg_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CFG) |=> $stable(chan_mode));
  // R4
  xor_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_PTR && chan_mode == M_XOR && bus_wdata[5:0] != 6'd0)
    |=> ($stable(ptr_q) && bus_addr != A_ACT) || bus_rdata[10]);
  // R9
  multi_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_ACT && $countones(bus_wdata[3:0]) > 1 && !dp_done)
    |=> $stable(chan_state));
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_done && chan_state == S_ACT) |=> (chan_state == S_IDLE && done_irq));
  // R10
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);
  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_irq) |-> $past(chan_state) == S_ACT);
endmodule

// File: tb/dma_chan_ctl_tb.sv
module dma_chan_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dp_done = 1'b0;
  logic [2:0]  chan_mode;
  logic [1:0]  chan_state;
  logic        done_irq;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  dma_chan_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dp_done(dp_done),
    .chan_mode(chan_mode), .chan_state(chan_state), .done_irq(done_irq)
  );

  always @(negedge clk) begin
    item_t it;
    logic [31:0] got;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      case (it.kind)
        0: got = bus_rdata;
        1: got = {30'd0, chan_state};
        2: got = {31'd0, done_irq};
        default: got = {29'd0, chan_mode};
      endcase
      vectors++;
      if (got !== it.exp) begin
        miscompares++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      miscompares++;
      $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic expect_rd(input logic [1:0] a, input logic [31:0] e, input string tag);
    item_t it;
    bus_addr = a;
    it.kind = 0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic expect_port(input int k, input logic [31:0] e, input string tag);
    item_t it;
    it.kind = k; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic pulse_done();
    dp_done = 1'b1;
    @(posedge clk); #1;
    dp_done = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    expect_port(1, 32'd0, "R1 state");
    expect_rd(2'd0, 32'h0000_1440, "R1 config");
    expect_rd(2'd3, 32'h0, "R1 activation");
    expect_rd(2'd2, 32'h0, "R1 pointer");
    expect_port(2, 32'd0, "R1 irq");
    expect_port(3, 32'd0, "R1 mode");
    // R2 config write keeps the mode
    wr(2'd0, 32'hFFFF_FFFF);
    expect_rd(2'd0, 32'hFFFF_FFF8, "R2 config all ones");
    wr(2'd1, 32'd2);
    wr(2'd0, 32'h0);
    expect_rd(2'd0, 32'h0000_0002, "R2 config cleared keeps CRC32");
    expect_port(3, 32'd2, "R2 mode port");
    // R3 mode select
    wr(2'd1, 32'd7);
    expect_rd(2'd1, 32'd2, "R3 code 7 ignored");
    wr(2'd1, 32'd5);
    expect_port(3, 32'd2, "R3 code 5 ignored");
    wr(2'd1, 32'd1);
    expect_rd(2'd1, 32'd1, "R3 XOR selected");
    // R4 alignment per mode
    wr(2'd2, 32'h0000_1020);
    expect_rd(2'd2, 32'h0, "R4 XOR misaligned pointer kept");
    expect_rd(2'd3, 32'h400, "R4 alignment flag");
    wr(2'd2, 32'h0000_1040);
    expect_rd(2'd2, 32'h0000_1040, "R4 XOR aligned pointer");
    wr(2'd3, 32'h700);
    expect_rd(2'd3, 32'h0, "R11 flags cleared");
    wr(2'd1, 32'd0);
    wr(2'd2, 32'h0000_1020);
    expect_rd(2'd2, 32'h0000_1020, "R4 copy accepts 32-byte alignment");
    wr(2'd2, 32'h0000_1011);
    expect_rd(2'd2, 32'h0000_1020, "R4 copy misaligned kept");
    expect_rd(2'd3, 32'h400, "R4 copy alignment flag");
    wr(2'd1, 32'd3);
    wr(2'd2, 32'h0000_1003);
    expect_rd(2'd2, 32'h0000_1003, "R4 ECC scrub no rule");
    wr(2'd3, 32'h400);
    wr(2'd1, 32'd0);
    // R5 start from idle
    wr(2'd3, 32'h1);
    expect_port(1, 32'd1, "R5 start from idle");
    expect_rd(2'd3, 32'h10, "R11 active status");
    // R6 start while active
    wr(2'd3, 32'h1);
    expect_rd(2'd3, 32'h210, "R6 start while active flag");
    wr(2'd3, 32'h200);
    expect_rd(2'd3, 32'h10, "R11 clear start flag");
    // R7 pause, then start from paused, then pause/restart
    wr(2'd3, 32'h4);
    expect_rd(2'd3, 32'h20, "R7 pause");
    wr(2'd3, 32'h1);
    expect_port(1, 32'd1, "R5 start from paused");
    wr(2'd3, 32'h4);
    wr(2'd3, 32'h8);
    expect_port(1, 32'd1, "R7 restart");
    // R9 illegal in active
    wr(2'd3, 32'h8);
    expect_rd(2'd3, 32'h110, "R9 restart while active");
    wr(2'd3, 32'h100);
    wr(2'd3, 32'h5);
    expect_rd(2'd3, 32'h110, "R9 two command bits");
    wr(2'd3, 32'h100);
    // R8 stop
    wr(2'd3, 32'h2);
    expect_port(1, 32'd0, "R8 stop from active");
    wr(2'd3, 32'h2);
    expect_rd(2'd3, 32'h0, "R8 stop while idle no-op");
    // R9 illegal in idle and paused
    wr(2'd3, 32'h4);
    expect_rd(2'd3, 32'h100, "R9 pause while idle");
    wr(2'd3, 32'h100);
    wr(2'd3, 32'h1);
    wr(2'd3, 32'h4);
    wr(2'd3, 32'h2);
    expect_rd(2'd3, 32'h120, "R9 stop while paused");
    wr(2'd3, 32'h108);
    expect_rd(2'd3, 32'h10, "R11 clear and restart together");
    // R10 completion
    pulse_done();
    expect_port(2, 32'd1, "R10 irq raised");
    expect_port(2, 32'd0, "R10 irq one cycle");
    expect_port(1, 32'd0, "R10 idle after done");
    pulse_done();
    expect_port(2, 32'd0, "R10 done while idle ignored");
    expect_port(1, 32'd0, "R10 state after ignored done");
    wr(2'd3, 32'h1);
    wr(2'd3, 32'h4);
    pulse_done();
    expect_port(1, 32'd2, "R10 done while paused ignored");
    expect_port(2, 32'd0, "R10 no irq while paused");
    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule